// File: doc/BRIEF.md
# Synchronous-to-Asynchronous Rate Converter

This block sits on the receive side of a modem data path. It takes a synchronous bit stream that arrives one bit per strobe at the line bit rate. That stream carries framed characters: a low start bit, data bits sent least significant first, and a high stop bit. The block re-times those characters onto an asynchronous serial output whose bit cells are timed by a 16x oversampling tick. Incoming bits are held in a small bit FIFO. High bits that sit between characters are marking and are dropped without costing any output time. A character is replayed only when its start bit and all of its data bits are buffered.

The far end may send slightly faster than nominal. When the FIFO backlog at the start of a stop bit is above a threshold, the block shortens that stop bit so the backlog drains. The standard overspeed range cuts the stop bit to 15/16 of a bit. The extended range cuts it to 7/8 of a bit (14 ticks). The nominal rate is selected between 2400 bit/s, where every oversampling tick counts, and 1200 bit/s, where every second tick counts. In bypass mode, used for FSK and synchronous operation, the converter is skipped: the output follows the input bit latched at each strobe, and the FIFO is cleared.

Top module: `sync_async_conv`

## Requirements
- R1: After reset, and whenever no complete character is waiting, the output line is high (1) and no start bit is produced.
- R2: A character is emitted as a low start bit, then the data bits least significant first, then a high stop bit. Each start and data bit lasts 16 bit-rate ticks. The character length code selects 8, 9, 10 or 11 total bits for codes 0 to 3, so there are 6 to 9 data bits.
- R3: A start bit is emitted only when the oldest buffered bit is low and at least (total bits minus one) bits are buffered. A partial character keeps the line high until the rest of it arrives.
- R4: A high bit at the head of the FIFO between characters is discarded without using output time. Marks between back-to-back characters therefore do not delay the next start bit.
- R5: The FIFO count is sampled as the stop bit begins, and it includes the incoming stop bit. If that count is at or below the threshold (default 4), the stop bit lasts a full 16 ticks.
- R6: If that count is above the threshold, the stop bit is shortened to 15 ticks with the extended-overspeed select at 0, or to 14 ticks with it at 1.
- R7: With the rate select at 1 (2400 bit/s), each oscillator tick counts as one bit-rate tick. With it at 0 (1200 bit/s), every second oscillator tick counts, which doubles all durations.
- R8: With bypass at 1, the output equals the input bit latched at the most recent strobe, one clock after that strobe. The FIFO is cleared and the framer is held idle, so the line is high once bypass returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-clock pulse at 16x the 2400 bit/s rate |
| rate_hi | input | 1 | 1 = 2400 bit/s, 0 = 1200 bit/s |
| ext_ovs | input | 1 | 1 = extended overspeed (14-tick short stop), 0 = standard (15-tick) |
| bypass | input | 1 | 1 = pass input bits straight through |
| char_len | input | 2 | Total character length code, 0..3 for 8..11 bits |
| in_stb | input | 1 | Synchronous bit strobe, one clock per received bit |
| in_bit | input | 1 | Synchronous data bit, sampled when in_stb is 1 |
| async_out | output | 1 | Asynchronous serial data line |

## Verification
The first pattern is a single isolated character. It shows that the frame is correct and that a lone stop bit keeps full width. Bursts of back-to-back characters, sent at both overspeed settings, separate the 15-tick and 14-tick stop bits, and the last character of each burst returns to a full stop. A burst with extra marks between characters lands the last stop decision exactly on the threshold. The same burst shows that dropped marks cost no time. A character split in two with a long pause between the halves shows that a start bit waits for the complete character. A slow-rate burst, a longest-length burst and a bypass sequence separate the rate divider, the length decoding and the pass-through path.

// File: rtl/sac_pkg.sv
package sac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } sac_state_t;

   // total character bits (start + data + stop) for a length code
   function automatic logic [3:0] char_bits(input logic [1:0] code);
      return 4'd8 + {2'b00, code};
   endfunction

endpackage

// File: rtl/sac_tick_gen.sv
module sac_tick_gen #(
   parameter int unsigned SLOW_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic os_tick,
   input  logic rate_hi,
   output logic tick_en
);

   generate
      if (SLOW_DIV < 2) begin : g_bad_div
         $error("sac_tick_gen: SLOW_DIV must be at least 2");
      end else begin : g_div
         localparam int unsigned PW = $clog2(SLOW_DIV);
         localparam logic [PW-1:0] PH_LAST = PW'(SLOW_DIV - 1);
         logic [PW-1:0] ph;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph <= '0;
            end else if (rate_hi) begin
               ph <= '0;
            end else if (os_tick) begin
               ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
            end
         end

         assign tick_en = os_tick & (rate_hi | (ph == PH_LAST));
      end
   endgenerate

endmodule

// File: rtl/sac_bit_fifo.sv
module sac_bit_fifo #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          din,
   input  logic          pop,
   output logic          head,
   output logic          empty,
   output logic [CW-1:0] count
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if ((DEPTH < 12) || ((1 << AW) != DEPTH)) begin : g_bad_depth
         $error("sac_bit_fifo: DEPTH must be a power of two of at least 12");
      end
      if (CW != $clog2(DEPTH + 1)) begin : g_bad_cw
         $error("sac_bit_fifo: CW does not match DEPTH");
      end
   endgenerate

   logic [DEPTH-1:0] mem;
   logic [AW-1:0]    wp;
   logic [AW-1:0]    rp;
   logic             full;
   logic             do_push;
   logic             do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !flush) begin
         mem[wp] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         unique case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sac_framer.sv
module sac_framer
   import sac_pkg::*;
#(
   parameter int unsigned TPB      = 16,
   parameter int unsigned STOP_STD = 15,
   parameter int unsigned STOP_EXT = 14,
   parameter int unsigned THRESH   = 4,
   parameter int unsigned CW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          tick_en,
   input  logic          ext_ovs,
   input  logic [1:0]    char_len,
   input  logic          head,
   input  logic          empty,
   input  logic [CW-1:0] count,
   output logic          pop,
   output logic          line,
   output sac_state_t    state
);

   localparam int unsigned TW = $clog2(TPB);
   localparam logic [TW-1:0] LAST_FULL = TW'(TPB - 1);
   localparam logic [TW-1:0] LAST_STD  = TW'(STOP_STD - 1);
   localparam logic [TW-1:0] LAST_EXT  = TW'(STOP_EXT - 1);
   localparam logic [CW-1:0] THR_CNT   = CW'(THRESH);

   generate
      if (!((STOP_EXT > 1) && (STOP_EXT <= STOP_STD) && (STOP_STD <= TPB))) begin : g_bad_stop
         $error("sac_framer: need 1 < STOP_EXT <= STOP_STD <= TPB");
      end
      if (CW < 4) begin : g_bad_cw
         $error("sac_framer: count too narrow for an 11-bit character");
      end
   endgenerate

   logic [TW-1:0] tcnt;
   logic [TW-1:0] stop_last;
   logic [3:0]    bidx;
   logic [3:0]    total;
   logic [3:0]    ndata;
   logic          mark;
   logic          start_ok;
   logic          bit_end;
   logic          stop_end;
   logic          last_data;

   assign total     = char_bits(char_len);
   assign ndata     = total - 4'd2;
   assign mark      = !empty && head;
   assign start_ok  = !empty && !head && (count >= CW'(total - 4'd1));
   assign bit_end   = (tcnt == LAST_FULL);
   assign stop_end  = (tcnt == stop_last);
   assign last_data = (bidx == ndata - 4'd1);

   always_comb begin
      pop = 1'b0;
      if (!hold) begin
         unique case (state)
            ST_IDLE:  pop = mark || (tick_en && start_ok);
            ST_START: pop = tick_en && bit_end;
            ST_DATA:  pop = tick_en && bit_end && !last_data;
            ST_STOP:  pop = mark || (tick_en && stop_end && start_ok);
            default:  pop = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         line      <= 1'b1;
         tcnt      <= '0;
         bidx      <= '0;
         stop_last <= LAST_FULL;
      end else if (hold) begin
         state <= ST_IDLE;
         line  <= 1'b1;
         tcnt  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (tick_en && start_ok) begin
                  state <= ST_START;
                  line  <= 1'b0;
                  tcnt  <= '0;
               end
            end
            ST_START: begin
               if (tick_en) begin
                  if (bit_end) begin
                     state <= ST_DATA;
                     line  <= head;
                     bidx  <= '0;
                     tcnt  <= '0;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (tick_en) begin
                  if (bit_end) begin
                     tcnt <= '0;
                     if (last_data) begin
                        state     <= ST_STOP;
                        line      <= 1'b1;
                        stop_last <= (count > THR_CNT) ?
                                     (ext_ovs ? LAST_EXT : LAST_STD) : LAST_FULL;
                     end else begin
                        line <= head;
                        bidx <= bidx + 4'd1;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (tick_en) begin
                  if (stop_end) begin
                     tcnt <= '0;
                     if (start_ok) begin
                        state <= ST_START;
                        line  <= 1'b0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sync_async_conv.sv
module sync_async_conv
   import sac_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned TPB        = 16,
   parameter int unsigned STOP_STD   = 15,
   parameter int unsigned STOP_EXT   = 14,
   parameter int unsigned THRESH     = 4,
   parameter int unsigned SLOW_DIV   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rate_hi,
   input  logic       ext_ovs,
   input  logic       bypass,
   input  logic [1:0] char_len,
   input  logic       in_stb,
   input  logic       in_bit,
   output logic       async_out
);

   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   logic             tick_en;
   logic             fifo_head;
   logic             fifo_empty;
   logic [CNT_W-1:0] fifo_cnt;
   logic             fifo_pop;
   logic             fr_line;
   sac_state_t       fr_state;
   logic             byp_q;

   sac_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .os_tick (os_tick),
      .rate_hi (rate_hi),
      .tick_en (tick_en)
   );

   sac_bit_fifo #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (bypass),
      .push  (in_stb & ~bypass),
      .din   (in_bit),
      .pop   (fifo_pop),
      .head  (fifo_head),
      .empty (fifo_empty),
      .count (fifo_cnt)
   );

   sac_framer #(
      .TPB      (TPB),
      .STOP_STD (STOP_STD),
      .STOP_EXT (STOP_EXT),
      .THRESH   (THRESH),
      .CW       (CNT_W)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (bypass),
      .tick_en  (tick_en),
      .ext_ovs  (ext_ovs),
      .char_len (char_len),
      .head     (fifo_head),
      .empty    (fifo_empty),
      .count    (fifo_cnt),
      .pop      (fifo_pop),
      .line     (fr_line),
      .state    (fr_state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= 1'b1;
      end else if (in_stb) begin
         byp_q <= in_bit;
      end
   end

   assign async_out = bypass ? byp_q : fr_line;

endmodule

// File: rtl/sac_checker.sv
module sac_checker
   import sac_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bypass,
   input logic          in_stb,
   input logic          in_bit,
   input logic          rate_hi,
   input logic          tick_en,
   input logic [1:0]    char_len,
   input sac_state_t    st,
   input logic          fr_line,
   input logic [CW-1:0] fifo_cnt,
   input logic          async_out
);

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> fr_line);

   assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |-> fr_line);

   assert_start_full_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && $past(st) != ST_START && !$past(bypass)) |->
      ($past(fifo_cnt) >= CW'(4'd7 + {2'b00, $past(char_len)})));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));

   assert_slow_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rate_hi && !$past(rate_hi) && $past(tick_en)) |-> !tick_en);

   assert_bypass_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_stb) && bypass && $past(bypass)) |-> (async_out == $past(in_bit)));

   assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (st == ST_IDLE && fifo_cnt == '0));

endmodule

bind sync_async_conv sac_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_sac_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bypass    (bypass),
   .in_stb    (in_stb),
   .in_bit    (in_bit),
   .rate_hi   (rate_hi),
   .tick_en   (tick_en),
   .char_len  (char_len),
   .st        (fr_state),
   .fr_line   (fr_line),
   .fifo_cnt  (fifo_cnt),
   .async_out (async_out)
);

// File: tb/test_sync_async_conv.sv
module test_sync_async_conv;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_CLKS  = 2;
   localparam int TPB        = 16;
   localparam int THR        = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rate_hi = 1'b1;
   logic       ext_ovs = 1'b0;
   logic       bypass = 1'b0;
   logic [1:0] char_len = 2'd2;
   logic       in_stb = 1'b0;
   logic       in_bit = 1'b1;
   logic       async_out;

   typedef struct {
      logic  lvl;
      int    nclk;
      bit    tail;
      string req;
   } seg_t;

   seg_t  exp_q[$];
   int    n_checks = 0;
   int    n_fail = 0;
   bit    mon_busy = 1'b0;
   bit    reported = 1'b0;

   sync_async_conv i_sync_async_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .os_tick   (os_tick),
      .rate_hi   (rate_hi),
      .ext_ovs   (ext_ovs),
      .bypass    (bypass),
      .char_len  (char_len),
      .in_stb    (in_stb),
      .in_bit    (in_bit),
      .async_out (async_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         os_tick = rst_n ? ~os_tick : 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      end
   endtask

   // monitor: sync on the falling edge of a start bit, then compare clock by clock
   initial begin
      seg_t cur;
      int   pos;
      int   bad_pos;
      logic prev = 1'b1;
      forever begin
         @(negedge clk);
         if (!mon_busy && exp_q.size() > 0 && prev === 1'b1 && async_out === 1'b0) begin
            cur = exp_q.pop_front();
            mon_busy = 1'b1;
            pos = 0;
            bad_pos = -1;
         end
         if (mon_busy) begin
            if (async_out !== cur.lvl && bad_pos < 0) bad_pos = pos;
            pos++;
            if (pos == cur.nclk) begin
               check(bad_pos < 0, cur.req, "segment level mismatch at clock offset",
                     bad_pos, -1);
               if (cur.tail || exp_q.size() == 0) begin
                  mon_busy = 1'b0;
               end else begin
                  cur = exp_q.pop_front();
                  pos = 0;
                  bad_pos = -1;
               end
            end
         end
         prev = async_out;
      end
   end

   task automatic wait_drain();
      while (exp_q.size() > 0 || mon_busy) @(negedge clk);
   endtask

   task automatic idle_check(input int n, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (async_out !== 1'b1) bad++;
      end
      check(bad == 0, req, "clocks with line low while idle", bad, 0);
   endtask

   task automatic push_bit(input logic b);
      @(negedge clk);
      in_stb = 1'b1;
      in_bit = b;
   endtask

   task automatic end_push();
      @(negedge clk);
      in_stb = 1'b0;
      in_bit = 1'b1;
   endtask

   // driver: predict the waveform, queue it, then feed the bits
   task automatic send_chars(input int n, input int d[4], input int code,
                             input int gap, input int split, input int pause,
                             input string req);
      int   L = 8 + code;
      int   nd = L - 2;
      int   div = rate_hi ? 1 : 2;
      int   bclk = TPB * TICK_CLKS * div;
      int   p = n * (L + gap);
      int   consumed = 0;
      int   rem;
      int   sclk;
      int   sent = 0;
      logic bits[$];
      for (int k = 0; k < n; k++) begin
         exp_q.push_back('{1'b0, bclk, 1'b0, req});
         bits.push_back(1'b0);
         for (int j = 0; j < nd; j++) begin
            exp_q.push_back('{logic'((d[k] >> j) & 1), bclk, 1'b0, req});
            bits.push_back(logic'((d[k] >> j) & 1));
         end
         rem = p - (consumed + L - 1);
         if (rem > THR) begin
            sclk = (ext_ovs ? 14 : 15) * TICK_CLKS * div;
            exp_q.push_back('{1'b1, sclk, k == n - 1, "R6"});
         end else begin
            exp_q.push_back('{1'b1, bclk, k == n - 1, "R5"});
         end
         bits.push_back(1'b1);
         for (int g = 0; g < gap; g++) bits.push_back(1'b1);
         consumed += L + gap;
      end
      foreach (bits[i]) begin
         if (split > 0 && sent == split) begin
            end_push();
            idle_check(pause, "R3");
         end
         push_bit(bits[i]);
         sent++;
      end
      end_push();
      wait_drain();
      idle_check(100, "R1");
   endtask

   initial begin
      int d[4];
      logic [7:0] pat;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(async_out === 1'b1, "R1", "line after reset", async_out, 1);
      idle_check(50, "R1");

      // single character, full stop
      char_len = 2'd2;
      d = '{8'h5A, 0, 0, 0};
      send_chars(1, d, 2, 0, 0, 0, "R2");

      // burst, standard overspeed
      d = '{8'hC3, 8'h01, 8'hFE, 0};
      send_chars(3, d, 2, 0, 0, 0, "R2");

      // burst, extended overspeed
      ext_ovs = 1'b1;
      d = '{8'h96, 8'h3C, 8'h80, 0};
      send_chars(3, d, 2, 0, 0, 0, "R6");

      // longest characters, nine data bits
      char_len = 2'd3;
      ext_ovs = 1'b0;
      d = '{9'h1A5, 9'h0F3, 0, 0};
      send_chars(2, d, 3, 0, 0, 0, "R2");

      // shortest characters with marks between them; last stop sits on threshold
      char_len = 2'd0;
      d = '{6'h2D, 6'h13, 0, 0};
      send_chars(2, d, 0, 3, 0, 0, "R4");

      // partial character held back until complete
      d = '{6'h35, 0, 0, 0};
      send_chars(1, d, 0, 0, 4, 300, "R3");

      // slow rate
      rate_hi = 1'b0;
      ext_ovs = 1'b1;
      char_len = 2'd2;
      d = '{8'h6E, 8'hB1, 0, 0};
      send_chars(2, d, 2, 0, 0, 0, "R7");
      rate_hi = 1'b1;
      ext_ovs = 1'b0;

      // bypass pass-through
      @(negedge clk);
      bypass = 1'b1;
      pat = 8'b1001_0110;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         in_stb = 1'b1;
         in_bit = pat[i];
         @(negedge clk);
         in_stb = 1'b0;
         check(async_out === pat[i], "R8", "bypass output after strobe", async_out, pat[i]);
         repeat (3) @(negedge clk);
         check(async_out === pat[i], "R8", "bypass output held", async_out, pat[i]);
      end
      @(negedge clk);
      bypass = 1'b0;
      @(negedge clk);
      check(async_out === 1'b1, "R8", "line after leaving bypass", async_out, 1);
      idle_check(100, "R8");

      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
   end

endmodule